// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Monitor

This block watches an already synchronized SCL level and checks two time limits at once. The first is the length of any single unbroken low phase of the clock. The second is the total time, summed over one message, during which this device has held SCL low to stretch it. The limit on that total is tighter when the device acts as bus master than when it acts as slave. Each limit has its own sticky flag. A masked OR of the flags drives one error interrupt line.

The surrounding I2C engine supplies one-cycle START and STOP detection pulses, the current role, and a level that is high while it is itself pulling SCL low. A small state machine follows the message framing. Its states are MON_OFF (monitor disabled), MON_IDLE (enabled, between a STOP and the next START) and MON_MSG (inside a message). The transitions are as follows:

- MON_OFF goes to MON_IDLE when enable rises.
- MON_IDLE goes to MON_MSG on a START.
- MON_MSG goes to MON_IDLE on a STOP.
- MON_IDLE and MON_MSG both go to MON_OFF when enable falls.
- MON_MSG stays in MON_MSG on a repeated START.

Counters run only in MON_MSG. The limits are clock-cycle counts derived from the system clock frequency, given in kHz: 25 ms for the continuous check, 10 ms for the master total and 25 ms for the slave total.

Top module: `sclk_low_watch`

## Requirements
- R1: While in a message with enable high, SCL low for 25*CLK_KHZ consecutive clock cycles sets flags bit 0 at the clock edge that completes the last of those cycles. One cycle fewer leaves bit 0 clear.
- R2: A single cycle of SCL high restarts the continuous low count, so two low phases that are each shorter than the limit never set bit 0.
- R3: In the master role (is_master high), the cycles with SCL low and self_stretch high are summed across low phases within one message. Bit 1 sets when the sum reaches 10*CLK_KHZ.
- R4: In the slave role (is_master low), the same sum is kept separately. Bit 2 sets when it reaches 25*CLK_KHZ.
- R5: Cycles with self_stretch low add nothing to either sum.
- R6: A START, including a repeated START inside a message, and a STOP both restart both sums from zero.
- R7: Between a STOP and the next START, nothing is counted and no flag sets. After enable rises, the monitor waits for a START before it counts.
- R8: While enable is low, nothing is counted and no flag sets. Dropping enable ends the current message.
- R9: Each flag stays set until a one-cycle pulse on the matching flag_clr bit clears it. Clearing one bit leaves the others unchanged. A flag that sets in the same cycle as its clear pulse stays set.
- R10: err_irq is high exactly when some set flag has its irq_en bit high, in the same cycle.
- R11: After reset, all flags are clear, err_irq is low and the monitor is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Monitor enable |
| scl_level | input | 1 | Synchronized SCL level |
| start_det | input | 1 | One-cycle START detection pulse |
| stop_det | input | 1 | One-cycle STOP detection pulse |
| is_master | input | 1 | High while this device acts as master |
| self_stretch | input | 1 | High while this device holds SCL low |
| irq_en | input | 3 | Per-flag interrupt enable |
| flag_clr | input | 3 | Per-flag clear pulse |
| flags | output | 3 | Sticky flags: bit 0 continuous, bit 1 master sum, bit 2 slave sum |
| err_irq | output | 1 | Combined error interrupt |

## Verification
The bench probes each limit one cycle below its threshold and exactly at it. A counter that is off by one would flag early or miss the threshold. It splits stretch time across several low phases and inserts repeated STARTs and STOPs. A design that cleared the sums on SCL high would never flag the split case, and one that ignored the restarts would flag where it must not. It drives long low periods while idle and while disabled, which a design that counted outside a message would flag. It also lines up a clear pulse with the setting edge, which a design that let the clear win would lose.

// File: rtl/sclk_low_pkg.sv
package sclk_low_pkg;

    localparam int NUM_CHK  = 3;
    localparam int IDX_CONT = 0;
    localparam int IDX_MEXT = 1;
    localparam int IDX_SEXT = 2;

    typedef logic [NUM_CHK-1:0] chk_vec_t;

    typedef enum logic [1:0] {
        MON_OFF  = 2'd0,
        MON_IDLE = 2'd1,
        MON_MSG  = 2'd2
    } mon_state_t;

    // time budget in milliseconds for each check
    function automatic int chk_ms(input int idx);
        case (idx)
            IDX_CONT: return 25;
            IDX_MEXT: return 10;
            default:  return 25;
        endcase
    endfunction

endpackage

// File: rtl/sclk_low_fsm.sv
module sclk_low_fsm
    import sclk_low_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_det,
    input  logic stop_det,
    output logic msg_live,
    output logic cum_restart
);

    mon_state_t state_q;
    mon_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_OFF: begin
                if (enable) state_d = MON_IDLE;
            end
            MON_IDLE: begin
                if (!enable)        state_d = MON_OFF;
                else if (start_det) state_d = MON_MSG;
            end
            MON_MSG: begin
                if (!enable)       state_d = MON_OFF;
                else if (stop_det) state_d = MON_IDLE;
            end
            default: state_d = MON_OFF;
        endcase
    end

    always_comb begin
        msg_live    = (state_q == MON_MSG) && enable && !stop_det;
        cum_restart = !msg_live || start_det;
    end

endmodule

// File: rtl/sclk_low_cnt.sv
module sclk_low_cnt #(
    parameter int LIMIT = 1000,
    localparam int W    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic hit
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != W'(LIMIT))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        hit = run && !clr && (cnt_q == W'(LIMIT - 1));
    end

endmodule

// File: rtl/sclk_flag_bank.sv
module sclk_flag_bank
    import sclk_low_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  chk_vec_t set_vec,
    input  chk_vec_t clr_vec,
    input  chk_vec_t mask,
    output chk_vec_t flag_q,
    output logic     irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_vec) | set_vec;
        end
    end

    always_comb begin
        irq = |(flag_q & mask);
    end

endmodule

// File: rtl/sclk_low_watch.sv
module sclk_low_watch
    import sclk_low_pkg::*;
#(
    parameter int CLK_KHZ = 100_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       scl_level,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       is_master,
    input  logic       self_stretch,
    input  logic [2:0] irq_en,
    input  logic [2:0] flag_clr,
    output logic [2:0] flags,
    output logic       err_irq
);

    logic     msg_live;
    logic     cum_restart;
    chk_vec_t run_vec;
    chk_vec_t clr_vec;
    chk_vec_t hit_vec;

    sclk_low_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .msg_live    (msg_live),
        .cum_restart (cum_restart)
    );

    always_comb begin
        run_vec[IDX_CONT] = msg_live && !scl_level;
        clr_vec[IDX_CONT] = !msg_live || scl_level;
        run_vec[IDX_MEXT] = msg_live && !scl_level && self_stretch && is_master;
        clr_vec[IDX_MEXT] = cum_restart;
        run_vec[IDX_SEXT] = msg_live && !scl_level && self_stretch && !is_master;
        clr_vec[IDX_SEXT] = cum_restart;
    end

    for (genvar g = 0; g < NUM_CHK; g++) begin : g_chk
        localparam int LIM = chk_ms(g) * CLK_KHZ;
        sclk_low_cnt #(
            .LIMIT (LIM)
        ) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run_vec[g]),
            .clr   (clr_vec[g]),
            .hit   (hit_vec[g])
        );
    end

    sclk_flag_bank i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (hit_vec),
        .clr_vec (flag_clr),
        .mask    (irq_en),
        .flag_q  (flags),
        .irq     (err_irq)
    );

endmodule

// File: rtl/sclk_low_watch_chk.sv
module sclk_low_watch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       scl_level,
    input logic       stop_det,
    input logic       is_master,
    input logic       self_stretch,
    input logic [2:0] flag_clr,
    input logic [2:0] flags,
    input logic       err_irq
);

    a_r1_cont_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(!scl_level));

    a_r3_mext_needs_master_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(is_master && self_stretch && !scl_level));

    a_r4_sext_needs_slave_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> $past(!is_master && self_stretch && !scl_level));

    a_r7_no_set_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> ((flags & ~$past(flags)) == 3'b000));

    a_r8_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((flags & ~$past(flags)) == 3'b000));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (flags != 3'b000));

endmodule

bind sclk_low_watch sclk_low_watch_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .scl_level    (scl_level),
    .stop_det     (stop_det),
    .is_master    (is_master),
    .self_stretch (self_stretch),
    .flag_clr     (flag_clr),
    .flags        (flags),
    .err_irq      (err_irq)
);

// File: tb/test_sclk_low_watch.sv
module test_sclk_low_watch;

    localparam int KHZ = 4;  // limits: continuous 100, master 40, slave 100

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       scl_level = 1'b1;
    logic       start_det = 1'b0;
    logic       stop_det = 1'b0;
    logic       is_master = 1'b0;
    logic       self_stretch = 1'b0;
    logic [2:0] irq_en = 3'b111;
    logic [2:0] flag_clr = 3'b000;
    logic [2:0] flags;
    logic       err_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sclk_low_watch #(.CLK_KHZ(KHZ)) i_sclk_low_watch (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .scl_level    (scl_level),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .is_master    (is_master),
        .self_stretch (self_stretch),
        .irq_en       (irq_en),
        .flag_clr     (flag_clr),
        .flags        (flags),
        .err_irq      (err_irq)
    );

    // vector: {master, stretch, low cycles[11:0], expected flags[2:0]}
    localparam int NV = 10;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 1'b1, 12'd39,  3'b000},
        {1'b1, 1'b1, 12'd40,  3'b010},
        {1'b1, 1'b0, 12'd60,  3'b000},
        {1'b0, 1'b1, 12'd60,  3'b000},
        {1'b0, 1'b1, 12'd99,  3'b000},
        {1'b0, 1'b1, 12'd100, 3'b101},
        {1'b1, 1'b0, 12'd100, 3'b001},
        {1'b1, 1'b1, 12'd100, 3'b011},
        {1'b0, 1'b0, 12'd99,  3'b000},
        {1'b1, 1'b0, 12'd99,  3'b000}
    };

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic low(input int n);
        scl_level = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic high(input int n);
        scl_level = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
    endtask

    task automatic do_stop();
        stop_det = 1'b1;
        @(negedge clk);
        stop_det = 1'b0;
    endtask

    task automatic clear(input logic [2:0] m);
        flag_clr = m;
        @(negedge clk);
        flag_clr = 3'b000;
    endtask

    initial begin : watchdog
        repeat (100_000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", {err_irq, flags}, 4'b0000);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        check("R11", {err_irq, flags}, 4'b0000);

        // table: R1 R3 R4 R5 thresholds
        for (int v = 0; v < NV; v++) begin
            clear(3'b111);
            do_start();
            is_master    = VEC[v][16];
            self_stretch = VEC[v][15];
            low(int'(VEC[v][14:3]));
            check("R1/R3/R4/R5 vector", {err_irq, flags}, {|VEC[v][2:0], VEC[v][2:0]});
            high(1);
            do_stop();
        end

        // R3: master sum spans several low phases
        clear(3'b111);
        do_start();
        is_master = 1'b1; self_stretch = 1'b1;
        low(25);
        high(3);
        low(14);
        check("R3 sum 39", {1'b0, flags}, 4'b0000);
        low(1);
        check("R3 sum 40", {1'b0, flags}, 4'b0010);
        high(1); do_stop();

        // R2: continuous count restarts on SCL high
        clear(3'b111);
        do_start();
        self_stretch = 1'b0;
        low(60); high(1); low(60);
        check("R2 split low", {1'b0, flags}, 4'b0000);
        low(40);
        check("R2 100 after restart", {1'b0, flags}, 4'b0001);
        high(1); do_stop();

        // R6: repeated START and STOP restart the sums
        clear(3'b111);
        do_start();
        self_stretch = 1'b1;
        low(30); high(1);
        do_start();
        low(30);
        check("R6 repeated start", {1'b0, flags}, 4'b0000);
        low(10);
        check("R6 40 after restart", {1'b0, flags}, 4'b0010);
        high(1); do_stop();
        clear(3'b111);
        do_start();
        low(30); high(1);
        do_stop();
        do_start();
        low(30);
        check("R6 stop restart", {1'b0, flags}, 4'b0000);
        high(1); do_stop();

        // R7: idle between STOP and START
        clear(3'b111);
        low(150);
        check("R7 idle", {1'b0, flags}, 4'b0000);
        high(1);

        // R8: disabled, then re-enabled waits for START
        do_start();
        low(20);
        enable = 1'b0;
        low(150);
        check("R8 disabled", {1'b0, flags}, 4'b0000);
        enable = 1'b1;
        low(150);
        check("R7 reenable waits for start", {1'b0, flags}, 4'b0000);
        high(1);

        // R9: sticky flags, per-bit clear, set beats clear
        do_start();
        low(100);
        check("R9 both set", {1'b0, flags}, 4'b0011);
        high(20);
        check("R9 sticky", {1'b0, flags}, 4'b0011);
        do_stop();
        clear(3'b010);
        check("R9 clear bit 1 only", {1'b0, flags}, 4'b0001);
        clear(3'b001);
        check("R9 clear bit 0", {1'b0, flags}, 4'b0000);
        do_start();
        low(39);
        flag_clr = 3'b010;
        @(negedge clk);
        flag_clr = 3'b000;
        check("R9 set beats clear", {1'b0, flags}, 4'b0010);
        high(1); do_stop();

        // R10: interrupt masking
        irq_en = 3'b101;
        #1;
        check("R10 masked", {err_irq, flags}, 4'b0010);
        irq_en = 3'b010;
        #1;
        check("R10 enabled", {err_irq, flags}, 4'b1010);
        clear(3'b111);
        check("R10 cleared", {err_irq, flags}, 4'b0000);

        summary();
    end

endmodule